// File: doc/BRIEF.md
# Looping Audio Buffer Address Engine

This block serves one audio stream (playback or capture) that is moved to or from memory through a circular buffer. Software sets a base address, a ring register and a block register. The ring register holds the buffer size in 32-bit words minus one in its low half and the live word index in its high half. The block register holds the block length in samples minus one in its low half and a live sample countdown in its high half. Each accepted transfer strobe from the sample datapath moves exactly one sample. The engine then advances the byte address and the sample countdown. When a block of samples is complete it raises a one-cycle done pulse.

The address is the base plus four times the word index plus a byte leftover in the range 0 to 3. The leftover collects the bytes of samples smaller than a word. A word carry moves the index on by one. In looping mode the index returns to zero once it passes the buffer size. In non-looping mode the index stops at the buffer size and the engine stops issuing addresses until software reprograms the ring.

A three-state controller sequences the channel. Its states are `ST_IDLE` (stopped), `ST_RUN` (addresses valid, strobes accepted) and `ST_STALL` (non-looping end reached). Its transitions are:
- IDLE to RUN when the channel is enabled and not paused.
- RUN to IDLE when the channel is disabled or paused.
- RUN to STALL when an accepted strobe hits the buffer end in non-looping mode.
- STALL to IDLE when the ring register is written or the channel is disabled or paused.

The parameter `HAS_PAUSE` set to 0 builds the capture variant, which has no pause control.

Top module: `audio_loop_dma`

## Requirements
- R1: After reset, `ring_cnt` and `blk_cnt` are 0, `byte_addr` equals `frame_base`, and `addr_valid` and `blk_done` are 0.
- R2: `fmt_code` bit 0 means stereo and bit 1 means 16-bit. One accepted strobe moves 1 << (bit0 + bit1) bytes, which is 1, 2, 2 or 4 bytes for codes 0, 1, 2 and 3.
- R3: `byte_addr` = `frame_base` + 4 × index (`ring_cnt[31:16]`) + leftover. The leftover is the byte total modulo 4. Each carry out of the leftover adds one to the index.
- R4: Each accepted strobe decrements the live sample count (`blk_cnt[31:16]`). A strobe that finds the count at 0 makes `blk_done` high for exactly the next cycle and reloads the count from the limit (`blk_cnt[15:0]`). Done therefore follows every limit+1 samples.
- R5: With `loop_off` = 0, an advance that would take the index past the size (`ring_cnt[15:0]`) sets the index to 0 and leaves the size unchanged.
- R6: With `loop_off` = 1, such an advance holds the index at the size and enters `ST_STALL`. In that state `addr_valid` is 0 and strobes change nothing. A ring write releases the stall.
- R7: A ring write loads the size from bits 15:0 and the index from bits 31:16, and clears the leftover to 0.
- R8: A block write replaces only the limit. The live sample count keeps its value.
- R9: Strobes take effect only in `ST_RUN` while `chan_en` is 1 and `chan_pause` is 0. `addr_valid` rises one cycle after the channel becomes runnable. When the channel is not runnable, strobes leave both counters and the address unchanged.
- R10: With `HAS_PAUSE` = 0, `chan_pause` has no effect and strobes still advance the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_base | input | AW | Buffer base byte address |
| ring_wr | input | 1 | Write strobe for the ring register |
| ring_wdata | input | 2*CW | Ring write data: index in the high half, size in the low half |
| blk_wr | input | 1 | Write strobe for the block limit |
| blk_limit | input | CW | New block length in samples minus one |
| fmt_code | input | 2 | Sample format: bit 0 stereo, bit 1 16-bit |
| chan_en | input | 1 | Channel enable |
| chan_pause | input | 1 | Channel pause (ignored when HAS_PAUSE = 0) |
| loop_off | input | 1 | 1 selects non-looping mode |
| xfer_stb | input | 1 | One sample moved by the datapath |
| byte_addr | output | AW | Current byte address |
| addr_valid | output | 1 | High in ST_RUN |
| ring_cnt | output | 2*CW | Live index and size |
| blk_cnt | output | 2*CW | Live sample count and limit |
| blk_done | output | 1 | One-cycle pulse at the end of a block |

## Verification
The embedded properties check on every cycle that:
- a ring write leaves a zero leftover;
- a loop wrap lands on index zero with the size unchanged;
- a non-looping end parks the index at the size, and the stall persists until it is released;
- a done pulse always follows an accepted strobe and coincides with a reloaded count;
- a limit write never disturbs the live count;
- a channel that is not runnable holds its counters.

Only the bench's scenarios show that the byte addresses are correct. These scenarios cover each format's step size, leftover carries in byte mode, the exact period of the done pulses, the one-cycle start-up latency, and the difference between the pausable and the pause-less variant.

// File: rtl/aldma_pkg.sv
`timescale 1ns/1ps
package aldma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } chan_state_t;

    localparam int unsigned FMT_W  = 2;
    localparam int unsigned LEFT_W = 2;

    // bytes per sample as a power of two: stereo bit plus width bit
    function automatic logic [1:0] fmt_shift(input logic [FMT_W-1:0] code);
        return {1'b0, code[0]} + {1'b0, code[1]};
    endfunction

endpackage

// File: rtl/aldma_ring.sv
`timescale 1ns/1ps
module aldma_ring #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base_addr,
    input  logic              wr_en,
    input  logic [2*CW-1:0]   wr_data,
    input  logic              adv,
    input  logic [1:0]        shift,
    input  logic              loop_off,
    output logic [2*CW-1:0]   ring_word,
    output logic [AW-1:0]     byte_addr,
    output logic              end_hit
);
    import aldma_pkg::*;

    localparam int unsigned SUM_W = LEFT_W + 2;

    logic [CW-1:0]     size_q;
    logic [CW-1:0]     idx_q;
    logic [LEFT_W-1:0] left_q;

    logic [SUM_W-1:0]  step_bytes;
    logic [SUM_W-1:0]  byte_sum;
    logic [1:0]        word_step;
    logic [CW:0]       idx_ext;
    logic              over;

    always_comb begin
        step_bytes = SUM_W'(1) << shift;
        byte_sum   = SUM_W'(left_q) + step_bytes;
        word_step  = byte_sum[SUM_W-1:LEFT_W];
        idx_ext    = {1'b0, idx_q} + (CW+1)'(word_step);
        over       = idx_ext > {1'b0, size_q};
        end_hit    = adv && !wr_en && over && loop_off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            idx_q  <= '0;
            left_q <= '0;
        end else if (wr_en) begin
            size_q <= wr_data[CW-1:0];
            idx_q  <= wr_data[2*CW-1:CW];
            left_q <= '0;
        end else if (adv) begin
            left_q <= byte_sum[LEFT_W-1:0];
            if (over) begin
                idx_q <= loop_off ? size_q : '0;
            end else begin
                idx_q <= idx_ext[CW-1:0];
            end
        end
    end

    always_comb begin
        ring_word = {idx_q, size_q};
        byte_addr = base_addr + (AW'(idx_q) << 2) + AW'(left_q);
    end

    AST_LEFT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (left_q == '0)); // R7

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && !loop_off && over) |=> (idx_q == '0) && $stable(size_q)); // R5

    AST_SAT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        end_hit |=> (idx_q == size_q)); // R6

endmodule

// File: rtl/aldma_blk.sv
`timescale 1ns/1ps
module aldma_blk #(
    parameter int unsigned CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_limit,
    input  logic            adv,
    output logic [2*CW-1:0] blk_word,
    output logic            done
);
    logic [CW-1:0] lim_q;
    logic [CW-1:0] live_q;
    logic          done_q;
    logic [CW-1:0] lim_n;
    logic          last;

    always_comb begin
        lim_n = wr_en ? wr_limit : lim_q;
        last  = (live_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= '0;
            live_q <= '0;
            done_q <= 1'b0;
        end else begin
            lim_q  <= lim_n;
            done_q <= adv && last;
            if (adv) begin
                live_q <= last ? lim_n : live_q - 1'b1;
            end
        end
    end

    always_comb begin
        blk_word = {live_q, lim_q};
        done     = done_q;
    end

    AST_DONE_FROM_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(adv)); // R4

    AST_DONE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (live_q == lim_q)); // R4

    AST_LIMIT_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !adv) |=> (live_q == $past(live_q))); // R8

endmodule

// File: rtl/aldma_ctrl.sv
`timescale 1ns/1ps
module aldma_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok,
    input  logic xfer_stb,
    input  logic ring_wr,
    input  logic end_hit,
    output logic adv,
    output logic addr_valid
);
    import aldma_pkg::*;

    chan_state_t st_q;
    chan_state_t st_n;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:  if (run_ok) st_n = ST_RUN;
            ST_RUN: begin
                if (!run_ok)      st_n = ST_IDLE;
                else if (end_hit) st_n = ST_STALL;
            end
            ST_STALL: if (ring_wr || !run_ok) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        addr_valid = (st_q == ST_RUN);
        adv        = xfer_stb && run_ok && (st_q == ST_RUN);
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL && !ring_wr && run_ok) |=> (st_q == ST_STALL)); // R6

    AST_END_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        end_hit |=> (st_q == ST_STALL) && !addr_valid); // R6

endmodule

// File: rtl/audio_loop_dma.sv
`timescale 1ns/1ps
module audio_loop_dma #(
    parameter int unsigned AW        = 32,
    parameter int unsigned CW        = 16,
    parameter bit          HAS_PAUSE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   frame_base,
    input  logic            ring_wr,
    input  logic [2*CW-1:0] ring_wdata,
    input  logic            blk_wr,
    input  logic [CW-1:0]   blk_limit,
    input  logic [1:0]      fmt_code,
    input  logic            chan_en,
    input  logic            chan_pause,
    input  logic            loop_off,
    input  logic            xfer_stb,
    output logic [AW-1:0]   byte_addr,
    output logic            addr_valid,
    output logic [2*CW-1:0] ring_cnt,
    output logic [2*CW-1:0] blk_cnt,
    output logic            blk_done
);
    import aldma_pkg::*;

    logic       run_ok;
    logic       adv;
    logic       end_hit;
    logic [1:0] shift;

    generate
        if (HAS_PAUSE) begin : g_pausable
            assign run_ok = chan_en && !chan_pause;
        end else begin : g_no_pause
            assign run_ok = chan_en;
        end
    endgenerate

    assign shift = fmt_shift(fmt_code);

    aldma_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok     (run_ok),
        .xfer_stb   (xfer_stb),
        .ring_wr    (ring_wr),
        .end_hit    (end_hit),
        .adv        (adv),
        .addr_valid (addr_valid)
    );

    aldma_ring #(.AW(AW), .CW(CW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_addr (frame_base),
        .wr_en     (ring_wr),
        .wr_data   (ring_wdata),
        .adv       (adv),
        .shift     (shift),
        .loop_off  (loop_off),
        .ring_word (ring_cnt),
        .byte_addr (byte_addr),
        .end_hit   (end_hit)
    );

    aldma_blk #(.CW(CW)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (blk_wr),
        .wr_limit (blk_limit),
        .adv      (adv),
        .blk_word (blk_cnt),
        .done     (blk_done)
    );

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && !ring_wr && !blk_wr) |=> $stable(ring_cnt) && $stable(blk_cnt)); // R9

endmodule

// File: tb/sim_audio_loop_dma.sv
`timescale 1ns/1ps
module sim_audio_loop_dma;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] ring;
        logic [31:0] blk;
        logic        done;
        logic        vld;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] frame_base = 32'h1000_0000;
    logic        ring_wr = 1'b0;
    logic [31:0] ring_wdata = '0;
    logic        blk_wr = 1'b0;
    logic [15:0] blk_limit = '0;
    logic [1:0]  fmt_code = 2'd3;
    logic        chan_en = 1'b0;
    logic        chan_pause = 1'b0;
    logic        loop_off = 1'b0;
    logic        xfer_stb = 1'b0;

    logic [31:0] byte_addr, ring_cnt, blk_cnt;
    logic        addr_valid, blk_done;
    logic [31:0] byte_addr1, ring_cnt1, blk_cnt1;
    logic        addr_valid1, blk_done1;

    int checks = 0;
    int errs = 0;
    exp_t q[$];

    // bench model
    logic [15:0] m_size = 0, m_idx = 0, m_lim = 0, m_live = 0;
    logic [1:0]  m_left = 0;
    bit          m_stalled = 0;

    always #10 clk = ~clk;

    audio_loop_dma u0 (
        .clk(clk), .rst_n(rst_n), .frame_base(frame_base),
        .ring_wr(ring_wr), .ring_wdata(ring_wdata),
        .blk_wr(blk_wr), .blk_limit(blk_limit), .fmt_code(fmt_code),
        .chan_en(chan_en), .chan_pause(chan_pause), .loop_off(loop_off),
        .xfer_stb(xfer_stb), .byte_addr(byte_addr), .addr_valid(addr_valid),
        .ring_cnt(ring_cnt), .blk_cnt(blk_cnt), .blk_done(blk_done)
    );

    audio_loop_dma #(.HAS_PAUSE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_base(frame_base),
        .ring_wr(ring_wr), .ring_wdata(ring_wdata),
        .blk_wr(blk_wr), .blk_limit(blk_limit), .fmt_code(fmt_code),
        .chan_en(chan_en), .chan_pause(chan_pause), .loop_off(loop_off),
        .xfer_stb(xfer_stb), .byte_addr(byte_addr1), .addr_valid(addr_valid1),
        .ring_cnt(ring_cnt1), .blk_cnt(blk_cnt1), .blk_done(blk_done1)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] m_addr();
        return frame_base + ({16'd0, m_idx} << 2) + {30'd0, m_left};
    endfunction

    // driver: one strobe, expectation pushed to the scoreboard
    task automatic strobe(input string req);
        exp_t e;
        bit   acc;
        int   nb;
        int   sum;
        int   nxt;
        acc = chan_en && !chan_pause && !m_stalled;
        e.done = 1'b0;
        if (acc) begin
            nb  = 1 << (int'(fmt_code[0]) + int'(fmt_code[1]));
            sum = int'(m_left) + nb;
            m_left = 2'(sum & 3);
            nxt = int'(m_idx) + (sum >> 2);
            if (nxt > int'(m_size)) begin
                if (loop_off) begin
                    m_idx = m_size;
                    m_stalled = 1;
                end else begin
                    m_idx = '0;
                end
            end else begin
                m_idx = 16'(nxt);
            end
            if (m_live == 0) begin
                e.done = 1'b1;
                m_live = m_lim;
            end else begin
                m_live = m_live - 1'b1;
            end
        end
        e.addr = m_addr();
        e.ring = {m_idx, m_size};
        e.blk  = {m_live, m_lim};
        e.vld  = chan_en && !chan_pause && !m_stalled;
        e.req  = req;
        q.push_back(e);
        xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0;
    endtask

    // monitor: compares the outputs after every strobe edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (xfer_stb) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    checks++; errs++;
                    $display("FAIL scoreboard: actual=empty expected=item");
                end else begin
                    e = q.pop_front();
                    chk(e.req, "byte_addr", byte_addr, e.addr);
                    chk(e.req, "ring_cnt", ring_cnt, e.ring);
                    chk(e.req, "blk_cnt", blk_cnt, e.blk);
                    chk(e.req, "blk_done", {31'd0, blk_done}, {31'd0, e.done});
                    chk(e.req, "addr_valid", {31'd0, addr_valid}, {31'd0, e.vld});
                end
            end
        end
    end

    task automatic ring_write(input logic [31:0] d);
        @(negedge clk);
        ring_wr = 1'b1; ring_wdata = d;
        @(negedge clk);
        ring_wr = 1'b0;
        m_size = d[15:0]; m_idx = d[31:16]; m_left = 0; m_stalled = 0;
        chk("R7", "ring after write", ring_cnt, d);
        chk("R7", "addr after write", byte_addr, m_addr());
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic blk_write(input logic [15:0] lim);
        @(negedge clk);
        blk_wr = 1'b1; blk_limit = lim;
        @(negedge clk);
        blk_wr = 1'b0;
        m_lim = lim;
        chk("R8", "blk after limit write", blk_cnt, {m_live, m_lim});
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] u1_addr;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "ring_cnt", ring_cnt, 32'd0);
        chk("R1", "blk_cnt", blk_cnt, 32'd0);
        chk("R1", "byte_addr", byte_addr, frame_base);
        chk("R1", "addr_valid", {31'd0, addr_valid}, 32'd0);
        chk("R1", "blk_done", {31'd0, blk_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 strobes while disabled are ignored
        strobe("R9");
        strobe("R9");

        ring_write(32'h0000_0007);
        blk_write(16'd3);
        chan_en = 1'b1;
        @(negedge clk);
        chk("R9", "addr_valid one cycle after enable", {31'd0, addr_valid}, 32'd1);

        // R4/R5: 16-bit stereo, wrap past 8 words, done every 4 samples
        fmt_code = 2'd3;
        for (int i = 0; i < 10; i++) strobe("R5");
        for (int i = 0; i < 3; i++) strobe("R4");

        // R2/R3: byte mode carries through the leftover
        fmt_code = 2'd0;
        for (int i = 0; i < 6; i++) strobe("R3");
        fmt_code = 2'd1;
        for (int i = 0; i < 3; i++) strobe("R2");
        fmt_code = 2'd2;
        for (int i = 0; i < 3; i++) strobe("R2");
        fmt_code = 2'd0;
        strobe("R3");

        // R7: ring write with a nonzero leftover
        ring_write(32'h0002_0009);
        strobe("R7");

        // R8: limit write keeps the live count
        blk_write(16'd1);
        for (int i = 0; i < 4; i++) strobe("R8");

        // R9/R10: pause ignored by the capture variant only
        fmt_code = 2'd3;
        ring_write(32'h0000_0007);
        chan_pause = 1'b1;
        settle();
        chk("R9", "addr_valid while paused", {31'd0, addr_valid}, 32'd0);
        u1_addr = byte_addr1;
        for (int i = 0; i < 3; i++) strobe("R9");
        chk("R10", "no-pause variant advanced", byte_addr1, u1_addr + 32'd12);
        chan_pause = 1'b0;
        chan_en = 1'b0;
        settle();
        for (int i = 0; i < 2; i++) strobe("R9");
        chan_en = 1'b1;
        settle();

        // R6: non-looping end
        loop_off = 1'b1;
        ring_write(32'h0000_0002);
        for (int i = 0; i < 5; i++) strobe("R6");
        chk("R6", "addr_valid in stall", {31'd0, addr_valid}, 32'd0);
        ring_write(32'h0001_0002);
        strobe("R6");

        repeat (3) @(negedge clk);
        chk("R4", "scoreboard drained", q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule